// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block moves N-bit words from a fast producer clock domain into a slower consumer clock domain. The producer writes with a write enable and a data word. The consumer reads with a read enable and sees the oldest unread word on its data output at all times (first-word fall-through). Each side keeps a binary address counter and a Gray-coded copy one bit wider than the address. Only the Gray copy crosses to the other domain, through two flip-flop stages.

The write side gets a full flag, an almost-full warning and its own empty flag, so the producer can tell when everything it wrote has been drained. The read side gets an empty flag. The depth is 2^ADDR_W. It is set at build time so the buffer can be made large enough for the burst sizes of the producer. Each domain has its own active-low reset.

Top module: `gray_async_fifo`

## Requirements
- R1: While and after reset, `wr_empty` and `rd_empty` are 1 and `wr_full` and `wr_almost_full` are 0.
- R2: Words leave in the order they were accepted. While `rd_empty` is 0, `rd_data` holds the oldest unread word. A read with `rd_en`=1 moves the output to the next word.
- R3: `wr_full` is 1 exactly when the write side counts DEPTH = 2^ADDR_W words held. It is set on the write clock edge that stores the last free slot.
- R4: `wr_almost_full` is 1 when the occupancy seen by the write side (write pointer minus synchronized read pointer, in binary) is at least DEPTH − ALMOST_MARGIN. With the defaults (ADDR_W=4, ALMOST_MARGIN=1) this means 15 or more words.
- R5: A write while `wr_full` is 1 is dropped. No slot or pointer changes, and the stored words are read back unchanged.
- R6: A read while `rd_empty` is 1 is dropped. The read pointer does not move, so the next word written is the next word read.
- R7: `rd_empty` rises on the read edge that consumes the last word. It falls within three read clocks after a write.
- R8: `wr_empty` is 0 on the write edge after a write. It returns to 1 within three write clocks after the read side has drained every word.
- R9: Each Gray pointer changes by at most one bit per clock edge of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-domain reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free slot |
| wr_almost_full | output | 1 | Occupancy at or above DEPTH − ALMOST_MARGIN |
| wr_empty | output | 1 | Write side sees no stored word |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-domain reset, active low |
| rd_en | input | 1 | Read request (consume current word) |
| rd_data | output | DATA_W | Oldest unread word |
| rd_empty | output | 1 | No word to read |

## Verification
The FIFO is first filled with reads held off. Occupancies of 14, 15 and 16 show where the almost-full warning switches on and where full switches on. Extra writes while full, with a marker value, show whether a dropped write corrupts a stored word or moves the pointer. Reads issued against an empty FIFO, followed by a single marked write, show whether the read pointer drifted. A long stream with writes and reads running at the same time, with gaps, across the 4:10 clock ratio, exercises pointer wrap and the two synchronizers. A scoreboard compares every word read against the order of the words written.

// File: rtl/gray_async_fifo.sv
module gray_async_fifo #(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 4,
  parameter int ALMOST_MARGIN = 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_almost_full,
  output logic              wr_empty,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] AF_LEVEL = (ADDR_W+1)'(DEPTH - ALMOST_MARGIN);

  function automatic logic [ADDR_W:0] g2b(input logic [ADDR_W:0] g);
    logic [ADDR_W:0] b;
    b[ADDR_W] = g[ADDR_W];
    for (int i = ADDR_W - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W:0] wbin, wgray, rq1, rq2;
  logic [ADDR_W:0] rbin, rgray, wq1, wq2;
  logic [ADDR_W:0] wbin_nx, rbin_nx, occ;
  logic            do_wr, do_rd;

  assign do_wr   = wr_en && !wr_full;
  assign do_rd   = rd_en && !rd_empty;
  assign wbin_nx = wbin + (ADDR_W+1)'(do_wr);
  assign rbin_nx = rbin + (ADDR_W+1)'(do_rd);

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
      rq1   <= rgray;
      rq2   <= rq1;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (do_wr) mem[wbin[ADDR_W-1:0]] <= wr_data;
  end

  assign occ            = wbin - g2b(rq2);
  assign wr_full        = wgray == {~rq2[ADDR_W:ADDR_W-1], rq2[ADDR_W-2:0]};
  assign wr_almost_full = occ >= AF_LEVEL;
  assign wr_empty       = wgray == rq2;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      wq1   <= wgray;
      wq2   <= wq1;
    end
  end

  assign rd_data  = mem[rbin[ADDR_W-1:0]];
  assign rd_empty = rgray == wq2;
endmodule

module gray_async_fifo_chk #(parameter int ADDR_W = 4) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              wr_en,
  input logic              wr_full,
  input logic              wr_almost_full,
  input logic              wr_empty,
  input logic [ADDR_W:0]   wgray,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              rd_en,
  input logic              rd_empty,
  input logic [ADDR_W:0]   rgray
);
  a_r9_wr_gray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  a_r9_rd_gray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  a_r5_hold_when_full: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_full) |=> wgray == $past(wgray));
  a_r6_hold_when_empty: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_empty) |=> rgray == $past(rgray));
  a_r3_full_not_empty: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !(wr_full && wr_empty));
  a_r4_full_implies_almost: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full |-> wr_almost_full);
endmodule

bind gray_async_fifo gray_async_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_full(wr_full),
  .wr_almost_full(wr_almost_full), .wr_empty(wr_empty), .wgray(wgray),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_empty(rd_empty),
  .rgray(rgray)
);

// File: tb/gray_async_fifo_bench.sv
module gray_async_fifo_bench;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_full, wr_almost_full, wr_empty, rd_empty;

  always #2 wr_clk = ~wr_clk;
  always #5 rd_clk = ~rd_clk;

  gray_async_fifo #(.DATA_W(DW), .ADDR_W(AW), .ALMOST_MARGIN(1)) u_gray_async_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_almost_full(wr_almost_full), .wr_empty(wr_empty),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty)
  );

  int checks = 0, errors = 0, popped = 0, pushed = 0;
  logic [DW-1:0] sb[$];
  bit drain_en = 0, force_rd = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    while (wr_full) @(negedge wr_clk);
    wr_en = 1; wr_data = d; sb.push_back(d); pushed++;
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic wait_drained();
    for (int t = 0; t < 2000 && (sb.size() != 0 || !rd_empty); t++) @(negedge rd_clk);
  endtask

  always @(negedge rd_clk) begin
    if (drain_en && !rd_empty) begin
      if (sb.size() == 0) chk(0, "R2 unexpected word", int'(rd_data), 0);
      else begin
        logic [DW-1:0] e;
        e = sb.pop_front();
        chk(rd_data == e, "R2/R5 read order", int'(rd_data), int'(e));
      end
      popped++;
      rd_en = 1;
    end else rd_en = force_rd;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge rd_clk);
    chk(wr_empty == 1, "R1 wr_empty in reset", wr_empty, 1);
    chk(rd_empty == 1, "R1 rd_empty in reset", rd_empty, 1);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (3) @(negedge wr_clk);
    chk(wr_empty == 1 && rd_empty == 1, "R1 empty after reset", {wr_empty, rd_empty}, 3);
    chk(wr_full == 0 && wr_almost_full == 0, "R1 full flags after reset", {wr_full, wr_almost_full}, 0);

    for (int i = 0; i < 14; i++) push(DW'(8'h10 + i));
    chk(wr_almost_full == 0, "R4 almost at 14", wr_almost_full, 0);
    chk(wr_empty == 0, "R8 wr_empty after write", wr_empty, 0);
    push(8'h1E);
    chk(wr_almost_full == 1, "R4 almost at 15", wr_almost_full, 1);
    chk(wr_full == 0, "R3 not full at 15", wr_full, 0);
    push(8'h1F);
    chk(wr_full == 1, "R3 full at 16", wr_full, 1);

    @(negedge wr_clk);
    wr_en = 1; wr_data = 8'hEE;
    repeat (3) @(negedge wr_clk);
    wr_en = 0;
    chk(wr_full == 1 && wr_almost_full == 1, "R5 flags after dropped writes", {wr_full, wr_almost_full}, 3);

    drain_en = 1;
    wait_drained();
    chk(popped == DEPTH, "R5 word count after full", popped, DEPTH);
    chk(rd_empty == 1, "R7 rd_empty after drain", rd_empty, 1);
    repeat (4) @(negedge wr_clk);
    chk(wr_empty == 1, "R8 wr_empty after drain", wr_empty, 1);
    chk(wr_full == 0 && wr_almost_full == 0, "R3 flags after drain", {wr_full, wr_almost_full}, 0);

    drain_en = 0; force_rd = 1;
    repeat (5) @(negedge rd_clk);
    force_rd = 0;
    push(8'h5A);
    for (int t = 0; t < 3 && rd_empty; t++) @(negedge rd_clk);
    chk(rd_empty == 0, "R7 rd_empty falls after write", rd_empty, 0);
    chk(rd_data == 8'h5A, "R6 word after empty reads", int'(rd_data), 8'h5A);
    drain_en = 1;
    wait_drained();

    for (int i = 0; i < 60; i++) begin
      push(DW'(i * 37 + 3));
      if (i % 7 == 3) repeat (5) @(negedge wr_clk);
    end
    wait_drained();
    chk(popped == pushed, "R2 stream count", popped, pushed);
    chk(rd_empty == 1, "R7 empty after stream", rd_empty, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule